// File: doc/BRIEF.md
# Second-Operand Shifter with Rotated Immediate

This block is purely combinational. It produces the second ALU operand and the shifter carry for a data-processing instruction. A form select picks one of two paths. The first path expands an 8-bit constant held in a 12-bit operand field. The second path takes a source register value and applies one of four shifts to it: logical left, logical right, arithmetic right or rotate right. The shift amount comes either from a 5-bit count inside the operand field or from the low byte of a second register.

Each shift encoding has its own edge cases: a zero count that stands for a full-width shift, a zero rotate that becomes a one-bit rotate through the carry, and register counts of 32 or more. The block resolves all of these so that the ALU sees a finished operand and the carry that the last displaced bit implies.

The block holds no state. A decoder turns the field into a small strobe struct, and a shift datapath acts on that struct.

Top module: `opnd2_shifter`

## Requirements
- R1: With `immSel`=1, `operandOut` is the value `opField[7:0]`, zero-extended to 32 bits and rotated right by twice `opField[11:8]`. The rotate is therefore even, from 0 to 30, and the number of set bits never changes.
- R2: With `immSel`=1, `carryOut` equals `carryIn` when `opField[11:8]` is 0. Otherwise `carryOut` equals bit 31 of `operandOut`.
- R3: With `immSel`=0, `opField[4]`=0 and `opField[6:5]`=00 (logical left) and a count n=`opField[11:7]`: for n from 1 to 31 the result is `rmVal`<<n with carry `rmVal[32-n]`. For n=0 the result is `rmVal` with carry `carryIn`.
- R4: Logical right (`opField[6:5]`=01) with a field count n from 1 to 31 gives `rmVal`>>n with carry `rmVal[n-1]`. A field count of 0 means a shift by 32: the result is 0 and the carry is `rmVal[31]`.
- R5: Arithmetic right (`opField[6:5]`=10) with a field count n from 1 to 31 shifts in copies of bit 31, with carry `rmVal[n-1]`. A field count of 0 means 32: every bit equals `rmVal[31]`, and so does the carry.
- R6: Rotate right (`opField[6:5]`=11) with a field count n from 1 to 31 rotates `rmVal` right by n, with carry `rmVal[n-1]`.
- R7: Rotate right with a field count of 0 is a one-bit rotate through the carry: the result is {`carryIn`, `rmVal[31:1]`} and the carry is `rmVal[0]`.
- R8: With `opField[4]`=1 the count is `rsVal[7:0]`, and the bits `rsVal[31:8]` have no effect. A count of 0 gives `rmVal` and `carryIn` for every shift type.
- R9: Register counts from 1 to 31 behave exactly as the same field counts do under R3 to R6.
- R10: A register count of exactly 32 gives the following. Logical left: result 0, carry `rmVal[0]`. Logical right: result 0, carry `rmVal[31]`. Arithmetic right: every bit and the carry equal `rmVal[31]`.
- R11: A register count above 32 gives the following. Logical left and logical right: result 0, carry 0. Arithmetic right: as in R10.
- R12: Rotate right by a register count of 32 or more uses the count modulo 32. When the count is a nonzero multiple of 32, the result is `rmVal` and the carry is `rmVal[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| immSel | input | 1 | 1 selects the rotated-constant form, 0 selects the shifted-register form |
| opField | input | 12 | Operand field of the instruction |
| rmVal | input | 32 | Value to be shifted in register form |
| rsVal | input | 32 | Register whose low byte supplies the shift count |
| carryIn | input | 1 | Current carry flag |
| operandOut | output | 32 | Second ALU operand |
| carryOut | output | 1 | Shifter carry |

## Verification
The block holds no state, so a wrong strobe from the decoder shows on the outputs within the same evaluation. A wrong strobe, such as a lost full-width flag or a missed pass-through, always lands on a specific count and type pair. The bench therefore sweeps every operand field value in immediate form, every field count and type in register form, and every register count from 0 to 255. It compares each result against a model that shifts one bit at a time. Most count errors show first in the carry, at counts 0, 1, 31, 32 and 33, because the result bits can agree while the carry does not.

// File: rtl/opnd2_pkg.sv
package opnd2_pkg;
  localparam int SHAMT_W = 8;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shiftKind_e;

  // strobes from decoder to datapath
  typedef struct packed {
    logic               useImm8;   // source is the zero-extended constant
    shiftKind_e         kind;
    logic [SHAMT_W-1:0] amount;    // effective count, full width already resolved
    logic               passThru;  // count of zero: value and carry unchanged
    logic               extRot;    // one-bit rotate through carry
  } shiftCtrl_t;
endpackage

// File: rtl/opnd2_decode.sv
module opnd2_decode
  import opnd2_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 12,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4
) (
  input  logic               immSel,
  input  logic [FIELD_W-1:0] opField,
  input  logic [SHAMT_W-1:0] rsAmt,
  output shiftCtrl_t         ctrl
);
  localparam int SH_W      = $clog2(DATA_W);
  localparam int SRC_BIT   = 4;
  localparam int TYPE_LSB  = 5;
  localparam int SHIMM_LSB = FIELD_W - SH_W;

  logic [SH_W-1:0]  fieldCount;
  logic [ROT_W-1:0] rotCount;
  shiftKind_e       regKind;

  assign fieldCount = opField[SHIMM_LSB +: SH_W];
  assign rotCount   = opField[IMM_W +: ROT_W];
  assign regKind    = shiftKind_e'(opField[TYPE_LSB +: 2]);

  always_comb begin
    ctrl = '0;
    if (immSel) begin
      ctrl.useImm8  = 1'b1;
      ctrl.kind     = SH_ROR;
      ctrl.amount   = SHAMT_W'({rotCount, 1'b0});
      ctrl.passThru = (rotCount == '0);
    end else begin
      ctrl.kind = regKind;
      if (opField[SRC_BIT]) begin
        ctrl.amount   = rsAmt;
        ctrl.passThru = (rsAmt == '0);
      end else if (fieldCount != '0) begin
        ctrl.amount = SHAMT_W'(fieldCount);
      end else begin
        unique case (regKind)
          SH_LSL:         ctrl.passThru = 1'b1;
          SH_LSR, SH_ASR: ctrl.amount   = SHAMT_W'(DATA_W);
          SH_ROR:         ctrl.extRot   = 1'b1;
          default:        ctrl.passThru = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/opnd2_shift.sv
module opnd2_shift
  import opnd2_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input  shiftCtrl_t        ctrl,
  input  logic [IMM_W-1:0]  imm8,
  input  logic [DATA_W-1:0] rmVal,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut
);
  localparam logic [SHAMT_W-1:0] FULL     = SHAMT_W'(DATA_W);
  localparam logic [SHAMT_W-1:0] BEYOND   = SHAMT_W'(DATA_W + 1);
  localparam logic [SHAMT_W-1:0] ROT_MASK = SHAMT_W'(DATA_W - 1);

  logic [DATA_W-1:0]        src;
  logic [SHAMT_W-1:0]       clampAmt, asrAmt, rorAmt;
  logic [2*DATA_W+1:0]      lslWide;
  logic [DATA_W:0]          lsrWide;
  logic signed [DATA_W:0]   asrWide;
  logic [2*DATA_W-1:0]      rorWide;

  assign src      = ctrl.useImm8 ? {{(DATA_W-IMM_W){1'b0}}, imm8} : rmVal;
  assign clampAmt = (ctrl.amount > FULL) ? BEYOND : ctrl.amount;
  assign asrAmt   = (ctrl.amount > FULL) ? FULL : ctrl.amount;
  assign rorAmt   = ctrl.amount & ROT_MASK;

  // bit DATA_W of the left product and bit 0 of the right products hold the last bit out
  assign lslWide = {{(DATA_W+2){1'b0}}, src} << clampAmt;
  assign lsrWide = {src, 1'b0} >> clampAmt;
  assign asrWide = $signed({src, 1'b0}) >>> asrAmt;
  assign rorWide = {src, src} >> rorAmt;

  always_comb begin
    result   = src;
    carryOut = carryIn;
    if (ctrl.passThru) begin
      result   = src;
      carryOut = carryIn;
    end else if (ctrl.extRot) begin
      result   = {carryIn, src[DATA_W-1:1]};
      carryOut = src[0];
    end else begin
      unique case (ctrl.kind)
        SH_LSL: begin
          result   = lslWide[DATA_W-1:0];
          carryOut = lslWide[DATA_W];
        end
        SH_LSR: begin
          result   = lsrWide[DATA_W:1];
          carryOut = lsrWide[0];
        end
        SH_ASR: begin
          result   = asrWide[DATA_W:1];
          carryOut = asrWide[0];
        end
        SH_ROR: begin
          result   = rorWide[DATA_W-1:0];
          carryOut = rorWide[DATA_W-1];
        end
        default: begin
          result   = src;
          carryOut = carryIn;
        end
      endcase
    end
  end
endmodule

// File: rtl/opnd2_shifter.sv
module opnd2_shifter
  import opnd2_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 12,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4
) (
  input  logic               immSel,
  input  logic [FIELD_W-1:0] opField,
  input  logic [DATA_W-1:0]  rmVal,
  input  logic [DATA_W-1:0]  rsVal,
  input  logic               carryIn,
  output logic [DATA_W-1:0]  operandOut,
  output logic               carryOut
);
  shiftCtrl_t ctrlBus;
  logic       unusedRsHigh;

  assign unusedRsHigh = ^rsVal[DATA_W-1:SHAMT_W];

  opnd2_decode #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
  ) decodeUnit (
    .immSel (immSel),
    .opField(opField),
    .rsAmt  (rsVal[SHAMT_W-1:0]),
    .ctrl   (ctrlBus)
  );

  opnd2_shift #(
    .DATA_W(DATA_W), .IMM_W(IMM_W)
  ) shiftUnit (
    .ctrl    (ctrlBus),
    .imm8    (opField[IMM_W-1:0]),
    .rmVal   (rmVal),
    .carryIn (carryIn),
    .result  (operandOut),
    .carryOut(carryOut)
  );
endmodule

// File: rtl/opnd2_shifter_chk.sv
module opnd2_shifter_chk #(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 12,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4
) (
  input logic               immSel,
  input logic [FIELD_W-1:0] opField,
  input logic [DATA_W-1:0]  rmVal,
  input logic [DATA_W-1:0]  rsVal,
  input logic               carryIn,
  input logic [DATA_W-1:0]  operandOut,
  input logic               carryOut
);
  logic       unusedChkHigh;
  logic [7:0] regAmt;
  logic [1:0] kindBits;

  assign unusedChkHigh = ^rsVal[DATA_W-1:8];
  assign regAmt        = rsVal[7:0];
  assign kindBits      = opField[6:5];

  always_comb begin
    if (immSel) begin
      // R1
      imm_popcount_chk: assert ($countones(operandOut) == $countones(opField[IMM_W-1:0]))
        else $error("rotated constant changed its bit count");
      if (opField[IMM_W +: ROT_W] == '0) begin
        // R2
        imm_norot_chk: assert (carryOut == carryIn &&
                               operandOut == {{(DATA_W-IMM_W){1'b0}}, opField[IMM_W-1:0]})
          else $error("unrotated constant altered");
      end else begin
        // R2
        imm_rot_carry_chk: assert (carryOut == operandOut[DATA_W-1])
          else $error("rotated constant carry differs from top bit");
      end
    end else if (opField[4]) begin
      if (regAmt == 8'd0) begin
        // R8
        reg_zero_pass_chk: assert (operandOut == rmVal && carryOut == carryIn)
          else $error("zero register count altered operand");
      end else if (regAmt > 8'(DATA_W) && !kindBits[1]) begin
        // R11
        big_logical_chk: assert (operandOut == '0 && !carryOut)
          else $error("logical shift beyond width left bits");
      end else if (regAmt >= 8'(DATA_W) && kindBits == 2'b10) begin
        // R10
        asr_fill_chk: assert (operandOut == {DATA_W{rmVal[DATA_W-1]}} &&
                              carryOut == rmVal[DATA_W-1])
          else $error("arithmetic shift beyond width not sign filled");
      end
    end else if (opField[11:7] == '0 && kindBits == 2'b11) begin
      // R7
      rrx_chk: assert (operandOut[DATA_W-1] == carryIn && carryOut == rmVal[0] &&
                       operandOut[DATA_W-2:0] == rmVal[DATA_W-1:1])
        else $error("extended rotate wrong");
    end
  end
endmodule

bind opnd2_shifter opnd2_shifter_chk #(
  .DATA_W(DATA_W), .FIELD_W(FIELD_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
) chk (
  .immSel(immSel), .opField(opField), .rmVal(rmVal), .rsVal(rsVal),
  .carryIn(carryIn), .operandOut(operandOut), .carryOut(carryOut)
);

// File: tb/opnd2_shifter_test.sv
module opnd2_shifter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        immSel = 1'b0;
  logic [11:0] opField = '0;
  logic [31:0] rmVal = '0;
  logic [31:0] rsVal = '0;
  logic        carryIn = 1'b0;
  logic [31:0] operandOut;
  logic        carryOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  opnd2_shifter uut (
    .immSel(immSel), .opField(opField), .rmVal(rmVal), .rsVal(rsVal),
    .carryIn(carryIn), .operandOut(operandOut), .carryOut(carryOut)
  );

  // reference: one bit at a time, carry tracking the last bit out
  function automatic logic [32:0] refModel(input logic imm, input logic [11:0] f,
                                           input logic [31:0] rm, input logic [31:0] rs,
                                           input logic cin);
    logic [31:0] v;
    logic        c;
    int          n;
    logic [1:0]  t;
    c = cin;
    if (imm) begin
      v = {24'b0, f[7:0]};
      n = 2 * int'(f[11:8]);
      t = 2'b11;
    end else begin
      v = rm;
      t = f[6:5];
      if (f[4]) n = int'(rs[7:0]);
      else begin
        n = int'(f[11:7]);
        if (n == 0) begin
          if (t == 2'b01 || t == 2'b10) n = 32;
          else if (t == 2'b11) return {rm[0], cin, rm[31:1]};
        end
      end
    end
    for (int i = 0; i < n; i++) begin
      case (t)
        2'b00: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'b01: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  function automatic string reqOf(input logic imm, input logic [11:0] f, input logic [31:0] rs);
    int a;
    if (imm) return (f[11:8] == 0) ? "R2" : "R1";
    if (!f[4]) begin
      case (f[6:5])
        2'b00: return "R3";
        2'b01: return "R4";
        2'b10: return "R5";
        default: return (f[11:7] == 0) ? "R7" : "R6";
      endcase
    end
    a = int'(rs[7:0]);
    if (a == 0) return "R8";
    if (a < 32) return "R9";
    if (f[6:5] == 2'b11) return "R12";
    if (a == 32) return "R10";
    return "R11";
  endfunction

  task automatic runOne(input logic imm, input logic [11:0] f, input logic [31:0] rm,
                        input logic [31:0] rs, input logic cin);
    logic [32:0] expv;
    string       req;
    @(posedge clk);
    #1;
    immSel = imm; opField = f; rmVal = rm; rsVal = rs; carryIn = cin;
    @(negedge clk);
    expv = refModel(imm, f, rm, rs, cin);
    req  = reqOf(imm, f, rs);
    checks++;
    if ({carryOut, operandOut} !== expv) begin
      fails++;
      $display("FAIL %s imm=%0b field=%h rm=%h rs=%h cin=%0b : got c=%0b v=%h exp c=%0b v=%h",
               req, imm, f, rm, rs, cin, carryOut, operandOut, expv[32], expv[31:0]);
    end
  endtask

  function automatic logic [31:0] pattern(input int k);
    case (k)
      0: return 32'h8000_0001;
      1: return 32'hA5A5_3C3C;
      2: return 32'h7FFF_FFFE;
      3: return 32'hFFFF_FFFF;
      4: return 32'h1234_5678;
      default: return 32'h0000_0000;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R3: quiescent all-zero inputs give zero operand and zero carry
    runOne(1'b0, 12'h000, 32'h0, 32'h0, 1'b0);

    // R1 R2: every constant field, both carry values
    for (int f = 0; f < 4096; f++)
      for (int c = 0; c < 2; c++)
        runOne(1'b1, 12'(f), 32'hDEAD_BEEF, 32'h0, c[0]);

    // R3 R4 R5 R6 R7: every field count and type, register unused bits varied
    for (int hi = 0; hi < 128; hi++)
      for (int k = 0; k < 6; k++)
        for (int c = 0; c < 2; c++)
          runOne(1'b0, {hi[6:0], 1'b0, 4'(k * 3)}, pattern(k), 32'hFFFF_FF00, c[0]);

    // R8 R9 R10 R11 R12: every register count byte, upper register bits noise
    for (int a = 0; a < 256; a++)
      for (int t = 0; t < 4; t++)
        for (int k = 0; k < 4; k++)
          for (int c = 0; c < 2; c++)
            runOne(1'b0, {5'(a * 7), t[1:0], 1'b1, 4'(k)}, pattern(k),
                   {24'(32'h00C3_5A96 ^ (a * 40503)), a[7:0]}, c[0]);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule